// File: doc/BRIEF.md
# Pointer-Register Address Generator

This block produces the data-memory address for a load or store that reaches memory through one of three 16-bit pointers, or through an absolute address carried in the instruction. Each pointer is a pair of byte registers taken from the top of the register file. The register file drives the six pointer bytes into the block as one flat vector. The block also reports the pointer value to write back for the auto-incrementing and auto-decrementing forms, together with the register-file index of the low byte that receives it.

A request is taken only while the block is idle. Every accepted request takes two cycles. The address is registered and stays unchanged across both cycles. Pointer write-back, when the mode calls for one, is signalled in the second cycle only. A request the block cannot serve (an offset on the first pointer, a pointer select with no pointer behind it, or an unused mode code) still occupies two cycles. During those cycles it raises an illegal flag, presents no address and writes nothing back.

Top module: `ptr_agu`

## Requirements
- R1: Pointer p (0, 1, 2) has its low byte in `ptr_regs_i[16p+7:16p]` and its high byte in `ptr_regs_i[16p+15:16p+8]`. These bytes are register-file entries 26+2p and 27+2p.
- R2: Mode 0 (plain) addresses the selected pointer unchanged and requests no write-back.
- R3: Mode 1 (post-increment) addresses the current pointer and writes back pointer+1.
- R4: Mode 2 (pre-decrement) addresses pointer-1 and writes back that same value.
- R5: Mode 3 (offset) addresses pointer plus the zero-extended 6-bit `disp_i` (0..63) for pointers 1 and 2, and requests no write-back.
- R6: Mode 4 (absolute) addresses `direct_i`, requests no write-back and ignores `sel_i`.
- R7: An accepted request holds `busy_o` and `addr_valid_o` high for exactly two cycles with a stable `addr_o`. A request raised while busy is ignored.
- R8: `wb_en_o` is high only in the second cycle of a request. `wb_reg_o` then holds 26+2p, the low-byte register index of the selected pointer.
- R9: Mode 3 on pointer 0, select value 3 in any mode but absolute, and mode codes 5..7 are illegal. For such a request `illegal_o` is high for both cycles, while `addr_valid_o` and `wb_en_o` stay low.
- R10: All pointer arithmetic wraps modulo 2^16. 0xFFFF+1 gives 0x0000, 0x0000-1 gives 0xFFFF, and an offset past 0xFFFF wraps.
- R11: After reset the block is idle, with `busy_o`, `addr_valid_o`, `wb_en_o` and `illegal_o` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Start an access, sampled while idle |
| sel_i | input | 2 | Pointer select: 0, 1 or 2 |
| mode_i | input | 3 | Addressing mode code |
| disp_i | input | 6 | Unsigned offset for mode 3 |
| direct_i | input | 16 | Absolute address for mode 4 |
| ptr_regs_i | input | 48 | Six pointer bytes, register 26 in the lowest byte |
| busy_o | output | 1 | Request in progress |
| addr_valid_o | output | 1 | `addr_o` carries a legal access address |
| addr_o | output | 16 | Effective data-memory address |
| wb_en_o | output | 1 | Write `wb_value_o` back to the pointer |
| wb_value_o | output | 16 | Updated pointer value |
| wb_reg_o | output | 5 | Register index of the pointer's low byte |
| illegal_o | output | 1 | Request cannot be served |

## Verification
The bench keeps the default build: three pointers based at register 26, a 6-bit offset and a 16-bit address. At that size it can step through every select code crossed with every mode code. Each combination is driven against pointer values that sit on the wrap edges (0x0000, 0xFFFF) and on the byte seams (0x00FF, 0xFF00). Offsets of 0 and 63 are applied, and pointers that push an offset across 0xFFFF. While each request is in flight, the bench also presents a conflicting second request with altered pointer bytes, to show that it is not taken.

// File: rtl/ptr_agu_pkg.sv
package ptr_agu_pkg;
  localparam int AGU_BW = 8;
  localparam int AGU_AW = 2 * AGU_BW;

  typedef enum logic [2:0] {
    AM_PLAIN   = 3'd0,
    AM_POSTINC = 3'd1,
    AM_PREDEC  = 3'd2,
    AM_OFFSET  = 3'd3,
    AM_ABS     = 3'd4
  } am_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ONE  = 2'd1,
    PH_TWO  = 2'd2
  } ph_e;

  // step a pointer by one, up or down, modulo 2^AGU_AW
  function automatic logic [AGU_AW-1:0] agu_step(input logic [AGU_AW-1:0] p,
                                                 input logic down);
    return down ? (p - {{(AGU_AW-1){1'b0}}, 1'b1}) : (p + {{(AGU_AW-1){1'b0}}, 1'b1});
  endfunction

  // add an already zero-extended offset, modulo 2^AGU_AW
  function automatic logic [AGU_AW-1:0] agu_offset(input logic [AGU_AW-1:0] p,
                                                   input logic [AGU_AW-1:0] ofs);
    return p + ofs;
  endfunction
endpackage

// File: rtl/ptr_agu_sel.sv
module ptr_agu_sel
  import ptr_agu_pkg::*;
#(
  parameter int NUM_PTR = 3,
  localparam int SEL_W  = $clog2(NUM_PTR + 1),
  localparam int VEC_W  = NUM_PTR * 2 * AGU_BW
) (
  input  logic [VEC_W-1:0]  ptr_regs_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [AGU_AW-1:0] ptr_o,
  output logic              sel_ok_o
);
  logic [AGU_AW-1:0] ptrs [NUM_PTR];

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_pair
    assign ptrs[g] = {ptr_regs_i[(2*g+1)*AGU_BW +: AGU_BW],
                      ptr_regs_i[(2*g)*AGU_BW   +: AGU_BW]};
  end

  always_comb begin
    ptr_o    = '0;
    sel_ok_o = 1'b0;
    for (int i = 0; i < NUM_PTR; i++) begin
      if (sel_i == SEL_W'(i)) begin
        ptr_o    = ptrs[i];
        sel_ok_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ptr_agu_calc.sv
module ptr_agu_calc
  import ptr_agu_pkg::*;
#(
  parameter int NUM_PTR      = 3,
  parameter int PTR_BASE     = 26,
  parameter int DISP_W       = 6,
  parameter int IDX_W        = 5,
  parameter int OFS_MIN_PTR  = 1,
  localparam int SEL_W       = $clog2(NUM_PTR + 1)
) (
  input  logic [2:0]        mode_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              sel_ok_i,
  input  logic [AGU_AW-1:0] ptr_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [AGU_AW-1:0] direct_i,
  output logic [AGU_AW-1:0] addr_o,
  output logic [AGU_AW-1:0] wb_val_o,
  output logic              wb_need_o,
  output logic              bad_o,
  output logic [IDX_W-1:0]  wb_idx_o
);
  logic ofs_ok;
  logic [AGU_AW-1:0] ptr_up, ptr_dn;

  assign ofs_ok = sel_ok_i && (int'(sel_i) >= OFS_MIN_PTR);
  assign ptr_up = agu_step(ptr_i, 1'b0);
  assign ptr_dn = agu_step(ptr_i, 1'b1);
  assign wb_idx_o = sel_ok_i ? IDX_W'(PTR_BASE + 2 * int'(sel_i)) : '0;

  always_comb begin
    addr_o    = '0;
    wb_val_o  = '0;
    wb_need_o = 1'b0;
    bad_o     = 1'b0;
    case (mode_i)
      AM_PLAIN: begin
        addr_o = ptr_i;
        bad_o  = !sel_ok_i;
      end
      AM_POSTINC: begin
        addr_o    = ptr_i;
        wb_val_o  = ptr_up;
        wb_need_o = 1'b1;
        bad_o     = !sel_ok_i;
      end
      AM_PREDEC: begin
        addr_o    = ptr_dn;
        wb_val_o  = ptr_dn;
        wb_need_o = 1'b1;
        bad_o     = !sel_ok_i;
      end
      AM_OFFSET: begin
        addr_o = agu_offset(ptr_i, AGU_AW'(disp_i));
        bad_o  = !ofs_ok;
      end
      AM_ABS: begin
        addr_o = direct_i;
      end
      default: begin
        bad_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/ptr_agu_ctrl.sv
module ptr_agu_ctrl
  import ptr_agu_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [AGU_AW-1:0] addr_i,
  input  logic [AGU_AW-1:0] wb_val_i,
  input  logic              wb_need_i,
  input  logic              bad_i,
  input  logic [IDX_W-1:0]  wb_idx_i,
  output logic              ph_one_o,
  output logic              ph_two_o,
  output logic              busy_o,
  output logic              addr_valid_o,
  output logic [AGU_AW-1:0] addr_o,
  output logic              wb_en_o,
  output logic [AGU_AW-1:0] wb_val_o,
  output logic [IDX_W-1:0]  wb_idx_o,
  output logic              illegal_o
);
  ph_e               ph_q;
  logic [AGU_AW-1:0] addr_q, wbv_q;
  logic [IDX_W-1:0]  idx_q;
  logic              need_q, bad_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      addr_q <= '0;
      wbv_q  <= '0;
      idx_q  <= '0;
      need_q <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      case (ph_q)
        PH_IDLE: if (req_i) begin
          ph_q   <= PH_ONE;
          addr_q <= addr_i;
          wbv_q  <= wb_val_i;
          idx_q  <= wb_idx_i;
          need_q <= wb_need_i && !bad_i;
          bad_q  <= bad_i;
        end
        PH_ONE:  ph_q <= PH_TWO;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign ph_one_o     = (ph_q == PH_ONE);
  assign ph_two_o     = (ph_q == PH_TWO);
  assign busy_o       = ph_one_o || ph_two_o;
  assign addr_valid_o = busy_o && !bad_q;
  assign illegal_o    = busy_o && bad_q;
  assign wb_en_o      = ph_two_o && need_q;
  assign addr_o       = addr_q;
  assign wb_val_o     = wbv_q;
  assign wb_idx_o     = idx_q;
endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
  import ptr_agu_pkg::*;
#(
  parameter int NUM_PTR     = 3,
  parameter int PTR_BASE    = 26,
  parameter int DISP_W      = 6,
  parameter int IDX_W       = 5,
  parameter int OFS_MIN_PTR = 1,
  localparam int SEL_W      = $clog2(NUM_PTR + 1),
  localparam int VEC_W      = NUM_PTR * 2 * AGU_BW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [2:0]        mode_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [AGU_AW-1:0] direct_i,
  input  logic [VEC_W-1:0]  ptr_regs_i,
  output logic              busy_o,
  output logic              addr_valid_o,
  output logic [AGU_AW-1:0] addr_o,
  output logic              wb_en_o,
  output logic [AGU_AW-1:0] wb_value_o,
  output logic [IDX_W-1:0]  wb_reg_o,
  output logic              illegal_o
);
  logic [AGU_AW-1:0] cur_ptr, nxt_addr, nxt_wbv;
  logic [IDX_W-1:0]  nxt_idx;
  logic              sel_ok, nxt_need, nxt_bad;
  logic              ev_phase1, ev_phase2;

  ptr_agu_sel #(.NUM_PTR(NUM_PTR)) u_sel (
    .ptr_regs_i (ptr_regs_i),
    .sel_i      (sel_i),
    .ptr_o      (cur_ptr),
    .sel_ok_o   (sel_ok)
  );

  ptr_agu_calc #(
    .NUM_PTR(NUM_PTR), .PTR_BASE(PTR_BASE), .DISP_W(DISP_W),
    .IDX_W(IDX_W), .OFS_MIN_PTR(OFS_MIN_PTR)
  ) u_calc (
    .mode_i    (mode_i),
    .sel_i     (sel_i),
    .sel_ok_i  (sel_ok),
    .ptr_i     (cur_ptr),
    .disp_i    (disp_i),
    .direct_i  (direct_i),
    .addr_o    (nxt_addr),
    .wb_val_o  (nxt_wbv),
    .wb_need_o (nxt_need),
    .bad_o     (nxt_bad),
    .wb_idx_o  (nxt_idx)
  );

  ptr_agu_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .addr_i       (nxt_addr),
    .wb_val_i     (nxt_wbv),
    .wb_need_i    (nxt_need),
    .bad_i        (nxt_bad),
    .wb_idx_i     (nxt_idx),
    .ph_one_o     (ev_phase1),
    .ph_two_o     (ev_phase2),
    .busy_o       (busy_o),
    .addr_valid_o (addr_valid_o),
    .addr_o       (addr_o),
    .wb_en_o      (wb_en_o),
    .wb_val_o     (wb_value_o),
    .wb_idx_o     (wb_reg_o),
    .illegal_o    (illegal_o)
  );
endmodule

// File: rtl/ptr_agu_chk.sv
module ptr_agu_chk
  import ptr_agu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ph1,
  input logic              ph2,
  input logic              busy,
  input logic              avalid,
  input logic [AGU_AW-1:0] addr,
  input logic              wb_en,
  input logic [AGU_AW-1:0] wb_val,
  input logic              illegal
);
  AST_PHASE_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    ph1 |=> ph2); // R7
  AST_PHASE_END: assert property (@(posedge clk) disable iff (!rst_n)
    ph2 |=> !busy); // R7
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ph2 |-> $stable(addr) && $stable(avalid)); // R7
  AST_WB_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> ph2 && avalid); // R8
  AST_WB_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_val == addr) || (wb_val == agu_step(addr, 1'b0))); // R3 R4
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !avalid && !wb_en); // R9
endmodule

bind ptr_agu ptr_agu_chk u_chk (
  .clk     (clk_i),
  .rst_n   (rst_ni),
  .ph1     (ev_phase1),
  .ph2     (ev_phase2),
  .busy    (busy_o),
  .avalid  (addr_valid_o),
  .addr    (addr_o),
  .wb_en   (wb_en_o),
  .wb_val  (wb_value_o),
  .illegal (illegal_o)
);

// File: tb/ptr_agu_tb_top.sv
`timescale 1ns/1ps
module ptr_agu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  sel = '0;
  logic [2:0]  mode = '0;
  logic [5:0]  disp = '0;
  logic [15:0] direct = '0;
  logic [47:0] regs = '0;
  logic        busy, avalid, wb_en, illegal;
  logic [15:0] addr, wb_val;
  logic [4:0]  wb_reg;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ptr_agu dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .sel_i(sel), .mode_i(mode),
    .disp_i(disp), .direct_i(direct), .ptr_regs_i(regs),
    .busy_o(busy), .addr_valid_o(avalid), .addr_o(addr), .wb_en_o(wb_en),
    .wb_value_o(wb_val), .wb_reg_o(wb_reg), .illegal_o(illegal)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // place pointer value v at pointer index p, filling the others with a distinct pattern
  function automatic logic [47:0] build_regs(input int p, input int v);
    logic [47:0] r;
    for (int k = 0; k < 3; k++) begin
      int w;
      w = (k == p) ? v : ((v ^ 16'h5A5A) + k * 16'h0101) & 16'hFFFF;
      r[k*16 +: 8]     = w[7:0];
      r[k*16 + 8 +: 8] = w[15:8];
    end
    return r;
  endfunction

  task automatic run_req(input int s, input int m, input int pv, input int d);
    int  e_addr, e_wbv;
    bit  e_bad, e_wb;
    string tag;
    e_bad = (m > 4) || (m != 4 && s == 3) || (m == 3 && s == 0);
    case (m)
      1:       e_addr = pv;
      2:       e_addr = (pv + 65535) % 65536;
      3:       e_addr = (pv + d) % 65536;
      4:       e_addr = (pv ^ 16'hA5C3);
      default: e_addr = pv;
    endcase
    e_wb  = !e_bad && (m == 1 || m == 2);
    e_wbv = (m == 1) ? (pv + 1) % 65536 : (pv + 65535) % 65536;
    case (m)
      0: tag = "R2"; 1: tag = "R3"; 2: tag = "R4"; 3: tag = "R5"; 4: tag = "R6";
      default: tag = "R9";
    endcase
    if (e_bad) tag = "R9";
    if (!e_bad && (pv == 0 || pv == 16'hFFFF || pv + d > 65535)) tag = {tag, "/R10"};

    @(negedge clk);
    sel = 2'(s); mode = 3'(m); disp = 6'(d);
    direct = 16'(pv ^ 16'hA5C3); regs = build_regs(s, pv); req = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R7 busy ph1", int'(busy), 1);
    check({tag, " illegal ph1"}, int'(illegal), int'(e_bad));
    check({tag, " valid ph1"}, int'(avalid), int'(!e_bad));
    if (!e_bad) check({tag, " R1 addr ph1"}, int'(addr), e_addr);
    check("R8 no wb ph1", int'(wb_en), 0);
    // conflicting request while busy must be ignored
    mode = 3'd1; sel = 2'd1; disp = 6'd17; direct = 16'h0F0F;
    regs = ~regs;
    @(posedge clk); @(negedge clk);
    check("R7 busy ph2", int'(busy), 1);
    if (!e_bad) check({tag, " R7 addr ph2"}, int'(addr), e_addr);
    check({tag, " R8 wb_en ph2"}, int'(wb_en), int'(e_wb));
    if (e_wb) begin
      check({tag, " wb value"}, int'(wb_val), e_wbv);
      check("R8 wb reg", int'(wb_reg), 26 + 2 * s);
    end
    req = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R7 idle after two", int'(busy) + int'(avalid) + int'(wb_en) + int'(illegal), 0);
  endtask

  initial begin
    int pats [6] = '{16'h0000, 16'hFFFF, 16'h00FF, 16'hFF00, 16'h1234, 16'hFFC5};
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 reset busy", int'(busy), 0);
    check("R11 reset valid", int'(avalid), 0);
    check("R11 reset wb", int'(wb_en), 0);
    check("R11 reset illegal", int'(illegal), 0);
    rst_n = 1'b1;
    for (int s = 0; s < 4; s++)
      for (int m = 0; m < 8; m++)
        for (int i = 0; i < 6; i++) begin
          run_req(s, m, pats[i], 63);
          run_req(s, m, pats[i], (i * 13) % 64);
        end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule